// File: doc/BRIEF.md
# T1 Receive Channel Timing Generator

This block produces the timing strobes for the receive side of one T1 framer. It runs on the 1.544 MHz receive line clock and walks the 193-bit frame: one framing bit, then 24 channels of 8 bits each. From that position it derives a channel clock that marks the last bit of every channel, a channel block strobe that covers the channels picked by a 24-bit mask, a frame sync on the framing bit, and a configurable sync that marks either frames or multiframes. On frames that carry signaling, the configurable sync can be stretched to two clocks. The current bit, channel and frame position are also driven out for downstream logic.

An external synchronizer owns the framing-pattern search. When it has found the frame, it pulses the alignment input once. The next cycle, the block is on the framing bit of frame 1, and it free-runs from there until it is told to align again. The block has no data stream, so there is no valid/ready handshake. The mask and the mode bits are plain static control pins. They may change at any time, and the outputs follow them in the same cycle.

Top module: `t1_rx_timing`

## Requirements
- R1: After a synchronous reset, and until the first alignment pulse, every strobe (chclk_o, chblk_o, fsync_o, sync_o, fbit_o) is low and bit_o, chan_o and frame_o are zero, even while clocks keep arriving.
- R2: On the clock edge that samples align_i high, the block loads the framing-bit position of frame 1. In the cycle that follows, fbit_o=1, fsync_o=1 and frame_o=0, and this holds whether the block was aligned before or not.
- R3: fsync_o is high for exactly one clock, on the framing bit, once every 193 clocks.
- R4: chclk_o is high exactly when bit_o==7, which is the least significant bit; bit 0 is the first bit (MSB) of a channel. It is low on the framing bit. Consecutive pulses are 8 clocks apart, or 9 clocks apart across the framing bit.
- R5: chblk_o is high during all 8 bits of channel n when blk_mask_i[n]=1, and low otherwise. Channel 0 is the first channel after the framing bit. chblk_o is low on the framing bit.
- R6: frame_o counts 0 to 11 when esf_i=0, or 0 to 23 when esf_i=1. It advances on entry to each framing bit and wraps to 0.
- R7: With msync_sel_i=0 and dbl_sig_i=0, sync_o equals fsync_o.
- R8: With msync_sel_i=1, sync_o is high for one clock on the framing bit of frame_o==0 only, and dbl_sig_i has no effect.
- R9: With msync_sel_i=0 and dbl_sig_i=1, sync_o is high on the framing bit and on the following clock (channel 0, bit 0) on signaling frames, which are frame_o values 5, 11, 17 and 23. On all other frames it stays single-wide.
- R10: After the framing bit, bit_o and chan_o step through bit 0..7 of channel 0 up to bit 7 of channel 23. While fbit_o=1, both bit_o and chan_o read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1.544 MHz receive line clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| align_i | input | 1 | One-clock pulse from the synchronizer: load framing bit of frame 1 |
| blk_mask_i | input | 24 | Per-channel block mask, bit n selects channel n |
| msync_sel_i | input | 1 | Sync select: 0 frame boundaries, 1 multiframe boundaries |
| dbl_sig_i | input | 1 | In frame mode, stretch sync to two clocks on signaling frames |
| esf_i | input | 1 | Multiframe length: 0 twelve frames, 1 twenty-four frames |
| chclk_o | output | 1 | Channel clock, high on each channel's last bit |
| chblk_o | output | 1 | Channel block strobe per mask |
| fsync_o | output | 1 | Frame sync, one clock on each framing bit |
| sync_o | output | 1 | Frame or multiframe sync, optionally double-wide |
| fbit_o | output | 1 | High during the framing bit |
| bit_o | output | 3 | Bit within channel, 0 = MSB |
| chan_o | output | 5 | Channel number 0..23 |
| frame_o | output | 5 | Frame within multiframe, 0 = frame 1 |

## Verification
The bench goes after four places. The first is the framing-bit seam, where a design off by one bit would space channel clocks 8 or 10 apart, or let the block strobe leak onto the framing bit. The second is the multiframe wrap in both lengths, where a wrong limit would put the multiframe sync on the wrong frame. The third is signaling frames 18 and 24, which exist only in the long multiframe, where a decoder that tests only 6 and 12 would leave those pulses single-wide. The fourth is a realign in mid-frame and the masks with the extreme channels set, which catch a counter that ignores the reload and a mask indexed in reverse.

// File: rtl/t1_rx_pkg.sv
package t1_rx_pkg;

  typedef struct packed {
    logic chclk;
    logic chblk;
    logic fsync;
    logic sync;
  } rx_strobe_t;

  function automatic logic sig_frame(input int frame_idx, input int period);
    return ((frame_idx + 1) % period) == 0;
  endfunction

endpackage

// File: rtl/t1_rx_poscnt.sv
module t1_rx_poscnt #(
  parameter int BITS_PER_CHAN = 8,
  parameter int CHANNELS      = 24,
  parameter int SF_FRAMES     = 12,
  parameter int ESF_FRAMES    = 24,
  localparam int BW = $clog2(BITS_PER_CHAN),
  localparam int CW = $clog2(CHANNELS),
  localparam int FW = $clog2(ESF_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          align_i,
  input  logic          esf_i,
  output logic          run_o,
  output logic          fbit_o,
  output logic [BW-1:0] bit_o,
  output logic [CW-1:0] chan_o,
  output logic [FW-1:0] frame_o
);

  localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_CHAN - 1);
  localparam logic [CW-1:0] CH_LAST  = CW'(CHANNELS - 1);
  localparam logic [FW-1:0] SF_LAST  = FW'(SF_FRAMES - 1);
  localparam logic [FW-1:0] ESF_LAST = FW'(ESF_FRAMES - 1);

  logic          run_q, fbit_q;
  logic [BW-1:0] bit_q;
  logic [CW-1:0] chan_q;
  logic [FW-1:0] frame_q;
  logic [FW-1:0] frame_last;

  assign frame_last = esf_i ? ESF_LAST : SF_LAST;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q   <= 1'b0;
      fbit_q  <= 1'b1;
      bit_q   <= '0;
      chan_q  <= '0;
      frame_q <= '0;
    end else if (align_i) begin
      run_q   <= 1'b1;
      fbit_q  <= 1'b1;
      bit_q   <= '0;
      chan_q  <= '0;
      frame_q <= '0;
    end else if (run_q) begin
      if (fbit_q) begin
        fbit_q <= 1'b0;
        bit_q  <= '0;
        chan_q <= '0;
      end else if (bit_q == BIT_LAST) begin
        bit_q <= '0;
        if (chan_q == CH_LAST) begin
          chan_q  <= '0;
          fbit_q  <= 1'b1;
          frame_q <= (frame_q >= frame_last) ? '0 : frame_q + 1'b1;
        end else begin
          chan_q <= chan_q + 1'b1;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign fbit_o  = fbit_q;
  assign bit_o   = bit_q;
  assign chan_o  = chan_q;
  assign frame_o = frame_q;

  AST_ALIGN_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    align_i |=> (run_q && fbit_q && frame_q == '0 && chan_q == '0 && bit_q == '0)); // R2

  AST_FRAME_END: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && !align_i && !fbit_q && chan_q == CH_LAST && bit_q == BIT_LAST) |=> fbit_q); // R3

  AST_FRAME_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_q <= ESF_LAST); // R6

  AST_FBIT_NO_REPEAT: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && fbit_q && !align_i) |=> !fbit_q); // R10

endmodule

// File: rtl/t1_rx_chstrobe.sv
module t1_rx_chstrobe #(
  parameter int BITS_PER_CHAN = 8,
  parameter int CHANNELS      = 24,
  localparam int BW = $clog2(BITS_PER_CHAN),
  localparam int CW = $clog2(CHANNELS),
  localparam int GW = $clog2(BITS_PER_CHAN + 2) + 1
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                align_i,
  input  logic                run_i,
  input  logic                fbit_i,
  input  logic [BW-1:0]       bit_i,
  input  logic [CW-1:0]       chan_i,
  input  logic [CHANNELS-1:0] mask_i,
  output logic                chclk_o,
  output logic                chblk_o
);

  localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_CHAN - 1);
  localparam logic [GW-1:0] GAP_MAX  = '1;

  logic in_chan;
  logic sel;

  assign in_chan = run_i && !fbit_i;

  always_comb begin
    sel = 1'b0;
    for (int n = 0; n < CHANNELS; n++) begin
      if (chan_i == CW'(n)) sel = mask_i[n];
    end
  end

  assign chclk_o = in_chan && (bit_i == BIT_LAST);
  assign chblk_o = in_chan && sel;

  // spacing monitor for the channel clock
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || align_i || !run_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (chclk_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_MAX) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_CHCLK_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (chclk_o && seen_q) |-> (gap_q == GW'(BITS_PER_CHAN - 1) || gap_q == GW'(BITS_PER_CHAN))); // R4

  AST_FBIT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    fbit_i |-> (!chclk_o && !chblk_o)); // R5

endmodule

// File: rtl/t1_rx_syncgen.sv
module t1_rx_syncgen
  import t1_rx_pkg::*;
#(
  parameter int BITS_PER_CHAN = 8,
  parameter int CHANNELS      = 24,
  parameter int ESF_FRAMES    = 24,
  parameter int SIG_PERIOD    = 6,
  localparam int BW = $clog2(BITS_PER_CHAN),
  localparam int CW = $clog2(CHANNELS),
  localparam int FW = $clog2(ESF_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          run_i,
  input  logic          fbit_i,
  input  logic [BW-1:0] bit_i,
  input  logic [CW-1:0] chan_i,
  input  logic [FW-1:0] frame_i,
  input  logic          msync_sel_i,
  input  logic          dbl_sig_i,
  output logic          fsync_o,
  output logic          sync_o
);

  logic on_fbit, first_slot, is_sig, tail;

  assign on_fbit    = run_i && fbit_i;
  assign first_slot = run_i && !fbit_i && chan_i == '0 && bit_i == '0;
  assign is_sig     = sig_frame(int'(frame_i), SIG_PERIOD);
  assign tail       = !msync_sel_i && dbl_sig_i && first_slot && is_sig;

  assign fsync_o = on_fbit;
  assign sync_o  = msync_sel_i ? (on_fbit && frame_i == '0) : (on_fbit || tail);

  AST_MSYNC_PLACE: assert property (@(posedge clk_i) disable iff (rst_i)
    (msync_sel_i && sync_o) |-> (fsync_o && frame_i == '0)); // R8

  AST_FSYNC_IN_SYNC: assert property (@(posedge clk_i) disable iff (rst_i)
    (!msync_sel_i && fsync_o) |-> sync_o); // R7

  AST_DBL_TAIL: assert property (@(posedge clk_i) disable iff (rst_i)
    (sync_o && !fsync_o) |-> (dbl_sig_i && !msync_sel_i && is_sig)); // R9

endmodule

// File: rtl/t1_rx_timing.sv
module t1_rx_timing
  import t1_rx_pkg::*;
#(
  parameter int BITS_PER_CHAN = 8,
  parameter int CHANNELS      = 24,
  parameter int SF_FRAMES     = 12,
  parameter int ESF_FRAMES    = 24,
  parameter int SIG_PERIOD    = 6
) (
  input  logic                                 clk_i,
  input  logic                                 rst_i,
  input  logic                                 align_i,
  input  logic [CHANNELS-1:0]                  blk_mask_i,
  input  logic                                 msync_sel_i,
  input  logic                                 dbl_sig_i,
  input  logic                                 esf_i,
  output logic                                 chclk_o,
  output logic                                 chblk_o,
  output logic                                 fsync_o,
  output logic                                 sync_o,
  output logic                                 fbit_o,
  output logic [$clog2(BITS_PER_CHAN)-1:0]     bit_o,
  output logic [$clog2(CHANNELS)-1:0]          chan_o,
  output logic [$clog2(ESF_FRAMES)-1:0]        frame_o
);

  localparam int BW = $clog2(BITS_PER_CHAN);
  localparam int CW = $clog2(CHANNELS);
  localparam int FW = $clog2(ESF_FRAMES);

  logic          run, fbit;
  logic [BW-1:0] bitp;
  logic [CW-1:0] chan;
  logic [FW-1:0] frame;
  rx_strobe_t    stb;

  t1_rx_poscnt #(
    .BITS_PER_CHAN(BITS_PER_CHAN), .CHANNELS(CHANNELS),
    .SF_FRAMES(SF_FRAMES), .ESF_FRAMES(ESF_FRAMES)
  ) u_pos (
    .clk_i(clk_i), .rst_i(rst_i), .align_i(align_i), .esf_i(esf_i),
    .run_o(run), .fbit_o(fbit), .bit_o(bitp), .chan_o(chan), .frame_o(frame)
  );

  t1_rx_chstrobe #(
    .BITS_PER_CHAN(BITS_PER_CHAN), .CHANNELS(CHANNELS)
  ) u_chs (
    .clk_i(clk_i), .rst_i(rst_i), .align_i(align_i), .run_i(run),
    .fbit_i(fbit), .bit_i(bitp), .chan_i(chan), .mask_i(blk_mask_i),
    .chclk_o(stb.chclk), .chblk_o(stb.chblk)
  );

  t1_rx_syncgen #(
    .BITS_PER_CHAN(BITS_PER_CHAN), .CHANNELS(CHANNELS),
    .ESF_FRAMES(ESF_FRAMES), .SIG_PERIOD(SIG_PERIOD)
  ) u_syn (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run), .fbit_i(fbit),
    .bit_i(bitp), .chan_i(chan), .frame_i(frame),
    .msync_sel_i(msync_sel_i), .dbl_sig_i(dbl_sig_i),
    .fsync_o(stb.fsync), .sync_o(stb.sync)
  );

  assign chclk_o = stb.chclk;
  assign chblk_o = stb.chblk;
  assign fsync_o = stb.fsync;
  assign sync_o  = stb.sync;
  assign fbit_o  = run && fbit;
  assign bit_o   = run ? bitp  : '0;
  assign chan_o  = run ? chan  : '0;
  assign frame_o = run ? frame : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !run |-> !(chclk_o || chblk_o || fsync_o || sync_o || fbit_o)); // R1

  AST_FSYNC_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (fsync_o && !align_i) |=> !fsync_o); // R3

  AST_CHCLK_LSB: assert property (@(posedge clk_i) disable iff (rst_i)
    chclk_o |-> (bit_o == BW'(BITS_PER_CHAN - 1) && !fbit_o)); // R4

endmodule

// File: tb/tb_t1_rx_timing.sv
module tb_t1_rx_timing;

  logic        clk = 1'b0;
  logic        rst_i = 1'b1;
  logic        align_i = 1'b0;
  logic [23:0] blk_mask_i = '0;
  logic        msync_sel_i = 1'b0;
  logic        dbl_sig_i = 1'b0;
  logic        esf_i = 1'b0;
  logic        chclk_o, chblk_o, fsync_o, sync_o, fbit_o;
  logic [2:0]  bit_o;
  logic [4:0]  chan_o, frame_o;

  always #5 clk = ~clk;

  t1_rx_timing dut (
    .clk_i(clk), .rst_i(rst_i), .align_i(align_i), .blk_mask_i(blk_mask_i),
    .msync_sel_i(msync_sel_i), .dbl_sig_i(dbl_sig_i), .esf_i(esf_i),
    .chclk_o(chclk_o), .chblk_o(chblk_o), .fsync_o(fsync_o), .sync_o(sync_o),
    .fbit_o(fbit_o), .bit_o(bit_o), .chan_o(chan_o), .frame_o(frame_o)
  );

  typedef struct {
    logic       chclk, chblk, fsync, sync, fbit;
    logic [2:0] bitp;
    logic [4:0] chan, frame;
    string      tsync;
    bit         idle;
    bit         fresh;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   m_run = 0;
  int   m_pos = 0;
  int   m_frame = 0;
  bit   m_fresh = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver: advance the reference model one edge, apply new inputs, push expectation
  task automatic step(input bit a, input bit r, input bit esf_n, input bit msel_n,
                      input bit dbl_n, input logic [23:0] mask_n);
    exp_t e;
    int   bp, ch;
    @(posedge clk);
    #1;
    if (rst_i) begin
      m_run = 0; m_pos = 0; m_frame = 0; m_fresh = 0;
    end else if (align_i) begin
      m_run = 1; m_pos = 0; m_frame = 0; m_fresh = 1;
    end else begin
      m_fresh = 0;
      if (m_run) begin
        if (m_pos == 192) begin
          m_pos = 0;
          m_frame = (m_frame >= (esf_i ? 23 : 11)) ? 0 : m_frame + 1;
        end else begin
          m_pos++;
        end
      end
    end
    rst_i = r; align_i = a; esf_i = esf_n;
    msync_sel_i = msel_n; dbl_sig_i = dbl_n; blk_mask_i = mask_n;
    bp = (m_pos == 0) ? 0 : (m_pos - 1) % 8;
    ch = (m_pos == 0) ? 0 : (m_pos - 1) / 8;
    e.idle  = !m_run;
    e.fresh = m_fresh;
    e.fbit  = m_run && m_pos == 0;
    e.fsync = e.fbit;
    e.bitp  = m_run ? 3'(bp) : 3'd0;
    e.chan  = m_run ? 5'(ch) : 5'd0;
    e.frame = m_run ? 5'(m_frame) : 5'd0;
    e.chclk = m_run && m_pos != 0 && bp == 7;
    e.chblk = m_run && m_pos != 0 && mask_n[ch];
    if (msel_n) begin
      e.sync = e.fsync && m_frame == 0;  e.tsync = "R8";
    end else begin
      e.sync = e.fsync || (dbl_n && m_run && m_pos == 1 && ((m_frame + 1) % 6 == 0));
      e.tsync = dbl_n ? "R9" : "R7";
    end
    sb.push_back(e);
  endtask

  // monitor: compare DUT against expectations away from the clock edge
  int gap = 0;
  bit gap_ok = 0;
  bit crossed = 0;
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.idle) begin
        chk("R1", "idle strobes", {chclk_o, chblk_o, fsync_o, sync_o, fbit_o}, 0);
        chk("R1", "idle position", {bit_o, chan_o, frame_o}, 0);
      end else begin
        chk(e.fresh ? "R2" : "R3", "fsync", fsync_o, e.fsync);
        chk(e.fresh ? "R2" : "R10", "fbit", fbit_o, e.fbit);
        chk("R4", "chclk", chclk_o, e.chclk);
        chk("R5", "chblk", chblk_o, e.chblk);
        chk(e.tsync, "sync", sync_o, e.sync);
        chk("R10", "bit/chan", {bit_o, chan_o}, {e.bitp, e.chan});
        chk(e.fresh ? "R2" : "R6", "frame", frame_o, e.frame);
      end
      if (e.idle || e.fresh) begin
        gap_ok = 0; gap = 0; crossed = 0;
      end else begin
        gap++;
        if (fbit_o) crossed = 1;
        if (chclk_o) begin
          if (gap_ok) chk("R4", "chclk spacing", gap, crossed ? 9 : 8);
          gap_ok = 1; gap = 0; crossed = 0;
        end
      end
    end
  end

  task automatic segment(input bit esf, input bit msel, input bit dbl,
                         input logic [23:0] mask, input int frames);
    step(1, 0, esf, msel, dbl, mask);
    repeat (frames * 193 + 3) step(0, 0, esf, msel, dbl, mask);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step(0, 1, 0, 0, 0, 24'h0);
    repeat (6) step(0, 0, 0, 0, 0, 24'hFFFFFF);       // R1 hold before align
    segment(0, 0, 0, $urandom, 36);                  // R3 R4 R5 R7 SF
    segment(0, 0, 1, 24'h800001, 36);                // R9 SF signaling, extreme channels
    segment(0, 1, 1, $urandom, 36);                  // R8 SF multiframe
    segment(1, 0, 1, $urandom, 72);                  // R9 ESF frames 18 and 24
    segment(1, 1, 0, 24'hFFFFFF, 72);                // R8 R6 ESF
    repeat (500) step(0, 0, 1, 0, 0, 24'h5A5A5A);
    segment(1, 0, 0, $urandom, 30);                  // R2 realign mid-frame, R7
    step(0, 1, 0, 0, 0, 24'h0);
    repeat (4) step(0, 0, 0, 0, 0, 24'hFFFFFF);       // R1 reset returns to idle
    @(posedge clk);
    @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule